// File: doc/BRIEF.md
# Dual-Pixel UXGA Video Timing Generator

This block produces the raster timing for a 1600 by 1200 panel that takes two pixels on every dot clock. One port carries the even pixel and the other carries the odd pixel. The horizontal counter therefore counts pixel pairs rather than single pixels. The block outputs horizontal and vertical sync, a data-enable, the current pair index and the current line index. It also drives both ports with a vertical colour-bar test pattern.

Two preset timing sets are built in. The standard-blanking set has wide porches. The reduced-blanking set shortens both blanking intervals. The mode select is sampled during reset, and after that only at the moment the raster wraps to the first pair of the first line, so a frame never mixes the two sets. A separate polarity input inverts both sync outputs. Downstream logic serialises the two 18-bit pixel words and generates the clocks; neither is part of this block.

Top module: `uxga_pair_timing`

## Requirements
- R1: While reset is low, pair_idx and line_idx are 0, de is 1, both syncs are at their inactive level, and both pixel words show the first bar colour.
- R2: With mode_sel=0, a line spans 1080 pairs (0..1079). hsync is active for pairs 832 through 927. Pairs 800..831 form the front porch and pairs 928..1079 the back porch.
- R3: With mode_sel=0, a frame has V_ACT active lines (1200 by default), then 1 front-porch line, 3 sync lines and 46 back-porch lines. vsync is active on lines V_ACT+1 through V_ACT+3.
- R4: With mode_sel=1, a line spans 912 pairs (0..911), and hsync is active for pairs 848 through 855.
- R5: With mode_sel=1, a frame has V_ACT active lines, then 12 front-porch lines, 1 sync line (line V_ACT+12) and 1 back-porch line.
- R6: de is 1 exactly when pair_idx < 800 and line_idx < V_ACT.
- R7: With neg_pol=0 the syncs are active-high. With neg_pol=1 both are inverted, with no latency: the change appears in the same cycle that neg_pol changes.
- R8: mode_sel is captured during reset and at the wrap from the last pair of the last line to pair 0 of line 0. A change at any other time does not alter the frame in progress.
- R9: The pixel words are {red[17:12], green[11:6], blue[5:0]}, with 6 bits per colour and bit 5 as the MSB. During active video, bar k = pair_idx/100. Its 3-bit colour code c is the bitwise inverse of k: c[2] sets red to 3F, c[1] sets green to 3F and c[0] sets blue to 3F, and each colour is 00 otherwise. The even and odd words of a pair are equal.
- R10: Both pixel words are 0 (black) whenever de is 0.
- R11: pair_idx advances by one on each clock and wraps to 0 after the last pair of the line. line_idx advances only at that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, one pixel pair per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | 0 = standard blanking, 1 = reduced blanking |
| neg_pol | input | 1 | 1 inverts both sync outputs |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pair_idx | output | 11 | Pixel-pair index within the line |
| line_idx | output | 11 | Line index within the frame |
| even_rgb | output | 18 | Even (first) pixel of the pair, {R,G,B} |
| odd_rgb | output | 18 | Odd (second) pixel of the pair, {R,G,B} |

## Verification
The bench samples the first and last pair of each blanking and sync region. A comparator that is off by one would move a sync edge by one pair or one line, and that shift shows at those points. The bench flips mode_sel early in a standard frame and then checks the last pair of that frame. A design that switched timing sets at once would wrap early and emit a short, malformed frame. The bench also toggles neg_pol and samples the sync outputs in the same cycle, so registered polarity logic shows a one-cycle lag. It probes the bar boundaries and the first blanking pair, where a wrong divisor or a missing blank mask would put colour into the porch.

// File: rtl/uxga_pair_timing.sv
module uxga_pair_timing #(
  parameter int H_ACT  = 800,
  parameter int H_FP_S = 32,
  parameter int H_SW_S = 96,
  parameter int H_BP_S = 152,
  parameter int H_FP_R = 48,
  parameter int H_SW_R = 8,
  parameter int H_BP_R = 56,
  parameter int V_ACT  = 1200,
  parameter int V_FP_S = 1,
  parameter int V_SW_S = 3,
  parameter int V_BP_S = 46,
  parameter int V_FP_R = 12,
  parameter int V_SW_R = 1,
  parameter int V_BP_R = 1,
  parameter int CW     = 6,
  localparam int H_TOT_S = H_ACT + H_FP_S + H_SW_S + H_BP_S,
  localparam int H_TOT_R = H_ACT + H_FP_R + H_SW_R + H_BP_R,
  localparam int V_TOT_S = V_ACT + V_FP_S + V_SW_S + V_BP_S,
  localparam int V_TOT_R = V_ACT + V_FP_R + V_SW_R + V_BP_R,
  localparam int HW = $clog2(H_TOT_S > H_TOT_R ? H_TOT_S : H_TOT_R),
  localparam int VW = $clog2(V_TOT_S > V_TOT_R ? V_TOT_S : V_TOT_R)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_sel,
  input  logic            neg_pol,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic [HW-1:0]   pair_idx,
  output logic [VW-1:0]   line_idx,
  output logic [3*CW-1:0] even_rgb,
  output logic [3*CW-1:0] odd_rgb
);

  localparam logic [HW-1:0] H_ACT_W  = HW'(H_ACT);
  localparam logic [HW-1:0] H_END_S  = HW'(H_TOT_S - 1);
  localparam logic [HW-1:0] H_END_R  = HW'(H_TOT_R - 1);
  localparam logic [HW-1:0] HS_BEG_S = HW'(H_ACT + H_FP_S);
  localparam logic [HW-1:0] HS_END_S = HW'(H_ACT + H_FP_S + H_SW_S);
  localparam logic [HW-1:0] HS_BEG_R = HW'(H_ACT + H_FP_R);
  localparam logic [HW-1:0] HS_END_R = HW'(H_ACT + H_FP_R + H_SW_R);
  localparam logic [HW-1:0] BAR_W    = HW'(H_ACT / 8);
  localparam logic [VW-1:0] V_ACT_W  = VW'(V_ACT);
  localparam logic [VW-1:0] V_END_S  = VW'(V_TOT_S - 1);
  localparam logic [VW-1:0] V_END_R  = VW'(V_TOT_R - 1);
  localparam logic [VW-1:0] VS_BEG_S = VW'(V_ACT + V_FP_S);
  localparam logic [VW-1:0] VS_END_S = VW'(V_ACT + V_FP_S + V_SW_S);
  localparam logic [VW-1:0] VS_BEG_R = VW'(V_ACT + V_FP_R);
  localparam logic [VW-1:0] VS_END_R = VW'(V_ACT + V_FP_R + V_SW_R);

  logic          mode_q;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          h_last, v_last, hs_raw, vs_raw;
  logic [2:0]    bar, code;
  logic [3*CW-1:0] pix;

  assign h_last = hcnt == (mode_q ? H_END_R : H_END_S);
  assign v_last = vcnt == (mode_q ? V_END_R : V_END_S);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt   <= '0;
      vcnt   <= '0;
      mode_q <= mode_sel;
    end else if (h_last) begin
      hcnt <= '0;
      if (v_last) begin
        vcnt   <= '0;
        mode_q <= mode_sel;
      end else begin
        vcnt <= vcnt + 1'b1;
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign hs_raw = mode_q ? (hcnt >= HS_BEG_R && hcnt < HS_END_R)
                         : (hcnt >= HS_BEG_S && hcnt < HS_END_S);
  assign vs_raw = mode_q ? (vcnt >= VS_BEG_R && vcnt < VS_END_R)
                         : (vcnt >= VS_BEG_S && vcnt < VS_END_S);

  assign hsync    = hs_raw ^ neg_pol;
  assign vsync    = vs_raw ^ neg_pol;
  assign de       = (hcnt < H_ACT_W) && (vcnt < V_ACT_W);
  assign pair_idx = hcnt;
  assign line_idx = vcnt;

  assign bar  = 3'(hcnt / BAR_W);
  assign code = ~bar;

  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign pix[c*CW +: CW] = {CW{de & code[c]}};
  end

  assign even_rgb = pix;
  assign odd_rgb  = pix;

endmodule

// File: rtl/uxga_pair_timing_chk.sv
module uxga_pair_timing_chk #(
  parameter int HW = 11,
  parameter int VW = 11,
  parameter int CW = 6,
  parameter int H_ACT = 800,
  parameter int V_ACT = 1200
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_q,
  input logic            neg_pol,
  input logic            vsync,
  input logic            de,
  input logic [HW-1:0]   pair_idx,
  input logic [VW-1:0]   line_idx,
  input logic [3*CW-1:0] even_rgb,
  input logic [3*CW-1:0] odd_rgb
);

  p_pair_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_idx != '0) |-> (pair_idx == $past(pair_idx) + 1'b1));

  p_line_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_idx != '0) |-> $stable(line_idx));

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (pair_idx != '0 || line_idx != '0)) |-> $stable(mode_q));

  p_dark_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (even_rgb == '0 && odd_rgb == '0));

  p_pair_equal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    even_rgb == odd_rgb);

  p_de_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (pair_idx < HW'(H_ACT) && line_idx < VW'(V_ACT)));

  p_vs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_idx < VW'(V_ACT)) |-> (vsync == neg_pol));

endmodule

bind uxga_pair_timing uxga_pair_timing_chk #(
  .HW(HW), .VW(VW), .CW(CW), .H_ACT(H_ACT), .V_ACT(V_ACT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .neg_pol(neg_pol),
  .vsync(vsync), .de(de), .pair_idx(pair_idx), .line_idx(line_idx),
  .even_rgb(even_rgb), .odd_rgb(odd_rgb)
);

// File: tb/sim_uxga_pair_timing.sv
module sim_uxga_pair_timing;
  localparam int TV_ACT = 4;
  localparam int HW = 11;
  localparam int VW = $clog2(TV_ACT + 50);
  localparam int HT_S = 1080, HT_R = 912;
  localparam int FR_S = HT_S * (TV_ACT + 50);
  localparam int FR_R = HT_R * (TV_ACT + 14);
  localparam int NV = 31;

  // columns: base frame (0 std, 1 first reduced, 2 second reduced), pair, line,
  // hsync, vsync, de, pixel word
  localparam int T_M  [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,
                               1,1,1,1,1,1,1,1,1,1,1,1,1,2};
  localparam int T_P  [NV] = '{0,99,100,831,832,450,927,928,799,800,1079,0,0,1079,0,500,1079,
                               0,799,911,847,848,855,856,250,650,0,0,911,0,0};
  localparam int T_L  [NV] = '{0,0,0,0,0,1,2,2,3,3,3,4,5,7,8,53,53,
                               0,0,0,1,1,1,1,2,3,15,16,16,17,0};
  localparam int T_HS [NV] = '{0,0,0,0,1,0,1,0,0,0,0,0,0,0,0,0,0,
                               0,0,0,0,1,1,0,0,0,0,0,0,0,0};
  localparam int T_VS [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,1,1,0,0,0,
                               0,0,0,0,0,0,0,0,0,0,1,1,0,0};
  localparam int T_DE [NV] = '{1,1,1,0,0,1,0,0,1,0,0,0,0,0,0,0,0,
                               1,1,0,0,0,0,0,1,1,0,0,0,0,1};
  localparam int T_PX [NV] = '{'h3FFFF,'h3FFFF,'h3FFC0,0,0,'h00FFF,0,0,0,0,0,0,0,0,0,0,0,
                               'h3FFFF,0,0,0,0,0,0,'h3F03F,'h0003F,0,0,0,0,'h3FFFF};

  logic clk = 1'b0, rst_n = 1'b0, mode_sel = 1'b0, neg_pol = 1'b0;
  logic hsync, vsync, de;
  logic [HW-1:0] pair_idx;
  logic [VW-1:0] line_idx;
  logic [17:0] even_rgb, odd_rgb;
  int cyc = 0, wd = 0, total = 0, bad = 0;
  logic timeout = 1'b0;

  always #4 clk = ~clk;

  uxga_pair_timing #(.V_ACT(TV_ACT)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .neg_pol(neg_pol),
    .hsync(hsync), .vsync(vsync), .de(de), .pair_idx(pair_idx),
    .line_idx(line_idx), .even_rgb(even_rgb), .odd_rgb(odd_rgb));

  always @(posedge clk) begin
    cyc <= rst_n ? cyc + 1 : 0;
    wd  <= wd + 1;
    if (wd >= 190000) timeout <= 1'b1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t && !timeout) @(negedge clk);
  endtask

  function automatic int base_of(input int m);
    return (m == 0) ? 0 : (m == 1) ? FR_S : FR_S + FR_R;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pair", int'(pair_idx), 0);
    chk("R1 line", int'(line_idx), 0);
    chk("R1 de", int'(de), 1);
    chk("R1 hsync", int'(hsync), 0);
    chk("R1 vsync", int'(vsync), 0);
    chk("R1 even", int'(even_rgb), 'h3FFFF);
    rst_n = 1'b1;

    // table walk: std frame (mode_sel flipped early, R8), then reduced frames
    for (int i = 0; i < NV; i++) begin
      wait_cyc(base_of(T_M[i]) + T_L[i] * ((T_M[i] == 0) ? HT_S : HT_R) + T_P[i]);
      if (timeout) break;
      chk("R11 R8 pair", int'(pair_idx), T_P[i]);
      chk("R11 R3 R5 line", int'(line_idx), T_L[i]);
      chk("R2 R4 hsync", int'(hsync), T_HS[i]);
      chk("R3 R5 vsync", int'(vsync), T_VS[i]);
      chk("R6 de", int'(de), T_DE[i]);
      chk("R9 R10 even", int'(even_rgb), T_PX[i]);
      chk("R9 R10 odd", int'(odd_rgb), T_PX[i]);
      if (i == 0) mode_sel = 1'b1;
    end

    // R8: mode captured in reset; R7: polarity inversion without latency
    rst_n = 1'b0;
    neg_pol = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 hsync idle inverted", int'(hsync), 1);
    rst_n = 1'b1;
    wait_cyc(848);
    chk("R8 R4 reduced from reset hsync", int'(hsync), 0);
    neg_pol = 1'b0;
    #1;
    chk("R7 same-cycle flip", int'(hsync), 1);
    chk("R7 vsync active-high idle", int'(vsync), 0);
    wait_cyc(912);
    chk("R8 R4 wrap pair", int'(pair_idx), 0);
    chk("R8 R4 wrap line", int'(line_idx), 1);

    if (timeout) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", wd);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule